// File: doc/BRIEF.md
# Shared strap and suspend-status pin controller

This block owns one bidirectional board pin that is used for two jobs in turn. While reset releases and for a short time afterwards, the pin is only an input. An external pull resistor on it selects how downstream port power is managed: pulled high means all ports switch together (gang mode), and pulled low means each port switches on its own (individual mode). The block samples the pin once through a two-flop synchronizer and keeps the result until the next reset.

Once a much longer delay has run out, the block enables the pin driver and uses the pin to report whether the chip is running or globally suspended. The polarity of that report depends on the strapped mode. Both delays come from one free-running counter, and they are set in microseconds against a clock-frequency parameter, so a simulation can use short windows. The pad itself lies outside the block, which supplies the output value and the output enable.

Top module: `strap_suspend_pin`

## Requirements
- R1: While reset is asserted, and just after it, oe_o is 0, pin_o is 0 and gang_o is 0.
- R2: The strap is sampled exactly once. The value of pin_i present at rising edge number STRAP_CYC-1 after reset release passes through a two-flop synchronizer and appears on gang_o after edge STRAP_CYC+1, where STRAP_CYC = (CLK_HZ/1e6)*STRAP_AT_US. A 1 selects gang mode (gang_o=1).
- R3: A strapped 0 selects individual mode (gang_o=0). Changes on pin_i before or after the sample edge have no effect on gang_o until the next reset.
- R4: oe_o rises after edge REL_CYC+1 following reset release, where REL_CYC = (CLK_HZ/1e6)*RELEASE_AT_US, and stays 1 until reset.
- R5: In gang mode with oe_o=1, pin_o equals suspend_i as sampled at the previous rising edge (0 running, 1 suspended).
- R6: In individual mode with oe_o=1, pin_o is the inverse of suspend_i as sampled at the previous rising edge (1 running, 0 suspended).
- R7: A reset asserted in the middle of the sequence returns the pin to input mode (oe_o=0, pin_o=0), clears gang_o and restarts both delays from zero.
- R8: While oe_o is 0, pin_o stays 0 whatever suspend_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Value read back from the shared pad |
| suspend_i | input | 1 | Global suspend flag, 1 when suspended |
| gang_o | output | 1 | Latched mode: 1 gang, 0 individual |
| oe_o | output | 1 | Pad output enable |
| pin_o | output | 1 | Value driven onto the pad when oe_o is 1 |

## Verification
The assertions check on every cycle that the output enable never drops once it is up, that the mode bit is frozen while the pin drives, that the output is quiet before release, and that the driven level follows the delayed suspend flag with the polarity of the strapped mode. They also tie a rising mode bit to the pin value three samples earlier. Only the bench scenarios can show the exact edge on which the strap is taken and the driver turns on, that strap glitches outside the sample edge are ignored, and that a reset in mid-sequence restarts both delays.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic {
    MODE_INDIV = 1'b0,
    MODE_GANG  = 1'b1
  } pwr_mode_e;

  // level driven on the pad for a given mode and suspend state
  function automatic logic status_level(pwr_mode_e mode, logic suspended);
    return (mode == MODE_GANG) ? suspended : ~suspended;
  endfunction

endpackage

// File: rtl/strap_seq_timer.sv
module strap_seq_timer #(
  parameter int unsigned STRAP_CYC = 10,
  parameter int unsigned REL_CYC   = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic strap_stb_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(REL_CYC + 1);
  localparam logic [CW-1:0] STRAP_V = CW'(STRAP_CYC);
  localparam logic [CW-1:0] REL_V   = CW'(REL_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q != REL_V)  cnt_q <= cnt_q + 1'b1;
  end

  assign strap_stb_o = (cnt_q == STRAP_V);
  assign done_o      = (cnt_q == REL_V);
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  logic      stb_i,
  output pwr_mode_e mode_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  pwr_mode_e              mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  // single capture; held until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= MODE_INDIV;
    else if (stb_i) mode_q <= pwr_mode_e'(sync_q[SYNC_STAGES-1]);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/status_driver.sv
module status_driver
  import strap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  pwr_mode_e mode_i,
  input  logic      suspend_i,
  output logic      oe_o,
  output logic      pin_o
);
  logic oe_q, pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      oe_q  <= en_i;
      pin_q <= en_i & status_level(mode_i, suspend_i);
    end
  end

  assign oe_o  = oe_q;
  assign pin_o = pin_q;
endmodule

// File: rtl/strap_suspend_pin.sv
module strap_suspend_pin
  import strap_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 12_000_000,
  parameter int unsigned STRAP_AT_US   = 10,
  parameter int unsigned RELEASE_AT_US = 50_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic suspend_i,
  output logic gang_o,
  output logic oe_o,
  output logic pin_o
);
  localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int unsigned STRAP_CYC  = CYC_PER_US * STRAP_AT_US;
  localparam int unsigned REL_CYC    = CYC_PER_US * RELEASE_AT_US;

  initial begin
    if (STRAP_CYC < 2 || STRAP_CYC >= REL_CYC)
      $error("strap_suspend_pin: bad delay parameters");
  end

  logic      strap_stb, done;
  pwr_mode_e mode;

  strap_seq_timer #(.STRAP_CYC(STRAP_CYC), .REL_CYC(REL_CYC)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strap_stb_o (strap_stb),
    .done_o      (done)
  );

  strap_sampler #(.SYNC_STAGES(2)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .stb_i  (strap_stb),
    .mode_o (mode)
  );

  status_driver u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (done),
    .mode_i    (mode),
    .suspend_i (suspend_i),
    .oe_o      (oe_o),
    .pin_o     (pin_o)
  );

  assign gang_o = (mode == MODE_GANG);
endmodule

// File: rtl/strap_suspend_pin_chk.sv
module strap_suspend_pin_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pin_i,
  input logic suspend_i,
  input logic gang_o,
  input logic oe_o,
  input logic pin_o
);
  p_oe_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |=> oe_o);

  p_mode_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> $stable(gang_o));

  p_quiet_before_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !pin_o);

  p_gang_polarity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && gang_o) |-> (pin_o == $past(suspend_i)));

  p_indiv_polarity_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !gang_o) |-> (pin_o == !$past(suspend_i)));

  p_strap_source_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gang_o) |-> $past(pin_i, 3));
endmodule

bind strap_suspend_pin strap_suspend_pin_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pin_i     (pin_i),
  .suspend_i (suspend_i),
  .gang_o    (gang_o),
  .oe_o      (oe_o),
  .pin_o     (pin_o)
);

// File: tb/strap_suspend_pin_tb.sv
module strap_suspend_pin_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_000_000;
  localparam int STRAP_US   = 10;
  localparam int REL_US     = 200;
  localparam int STRAP_CYC  = STRAP_US;
  localparam int REL_CYC    = REL_US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic susp = 1'b0;
  logic gang, oe, pout;

  int total = 0;
  int bad = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_suspend_pin #(
    .CLK_HZ(CLK_HZ), .STRAP_AT_US(STRAP_US), .RELEASE_AT_US(REL_US)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .suspend_i(susp),
    .gang_o(gang), .oe_o(oe), .pin_o(pout)
  );

  // behavioural reference
  int   edges;
  bit   pin_hist[$];
  logic m_gang, m_oe, m_pin;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges = 0; pin_hist.delete();
      m_gang = 0; m_oe = 0; m_pin = 0;
    end else begin
      pin_hist.push_back(pin);
      if (pin_hist.size() > 3) void'(pin_hist.pop_front());
      if (edges == STRAP_CYC) m_gang = pin_hist[0];
      m_oe  = (edges >= REL_CYC);
      m_pin = m_oe ? (m_gang ? susp : !susp) : 1'b0;
      edges++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(gang === m_gang, (edges <= STRAP_CYC) ? "R2" : "R3", gang, m_gang);
      check(oe === m_oe, "R4", oe, m_oe);
      check(pout === m_pin, !m_oe ? "R8" : (m_gang ? "R5" : "R6"), pout, m_pin);
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic do_reset(bit strap);
    @(negedge clk); #1;
    rst_n = 1'b0; pin = strap;
    #1;
    check(oe === 1'b0 && pout === 1'b0 && gang === 1'b0, "R1 R7",
          {gang, oe, pout}, 0);
    cyc(2);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cmp_on = 1'b1;
    // gang strap; later pin changes ignored
    do_reset(1'b1);
    cyc(30); pin = 1'b0;
    cyc(150);
    susp = 1'b1; cyc(40);
    check(oe === 1'b1 && pout === 1'b1, "R5", pout, 1);
    susp = 1'b0; cyc(5);
    check(pout === 1'b0, "R5", pout, 0);
    pin = 1'b1; susp = 1'b1; cyc(3); susp = 1'b0; cyc(3);
    check(gang === 1'b1, "R3", gang, 1);

    // individual strap with glitches around the sample edge
    do_reset(1'b0);
    cyc(STRAP_CYC - 3); pin = 1'b1; cyc(1); pin = 1'b0; cyc(1); pin = 1'b1;
    cyc(1); pin = 1'b0; cyc(10);
    check(gang === 1'b0, "R3", gang, 0);
    susp = 1'b1; cyc(50); susp = 1'b0; cyc(100);
    check(pout === 1'b0 && oe === 1'b0, "R8", pout, 0);
    cyc(60);
    check(oe === 1'b1 && pout === 1'b1, "R6", pout, 1);
    susp = 1'b1; cyc(2);
    check(pout === 1'b0, "R6", pout, 0);
    susp = 1'b0;

    // strap exactly at sample edge only
    do_reset(1'b0);
    cyc(STRAP_CYC - 2); pin = 1'b1; cyc(1); pin = 1'b0; cyc(5);
    check(gang === 1'b1, "R2", gang, 1);

    // mid-sequence reset restarts everything
    cyc(120);
    do_reset(1'b0);
    cyc(1);
    check(oe === 1'b0 && gang === 1'b0, "R7", {gang, oe}, 0);
    cyc(REL_CYC - 5);
    check(oe === 1'b0, "R7", oe, 0);
    cyc(10);
    check(oe === 1'b1 && pout === 1'b1, "R7", {oe, pout}, 3);
    cyc(20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule